// File: doc/BRIEF.md
# Snooping Coherence Line Controller

This block keeps a small direct-mapped, write-back cache coherent with its peers on a shared snooping bus. Each line is Invalid, Shared, Exclusive or Modified; the Exclusive state is used only when the `MESI_EN` parameter is set, and otherwise the block runs a plain three-state protocol. The processor side is a valid/ready request port. The bus side has a request/grant pair for arbitration, a command output, and snoop inputs that report the transactions of other masters.

A processor request that cannot finish locally raises `bus_req`. The request stays raised from that cycle until the cycle in which the transaction finishes. When the bus is granted, the command is chosen from the line's state at that moment. A dirty victim is written back first while the bus is still held. Then comes a fill (read or read-exclusive) or an upgrade. The bus is atomic: fill data and the shared-response wire are sampled in the same cycle as the command. Snooped transactions can invalidate local copies, demote them to Shared, or make the block supply dirty data on `snp_data`.

Back-pressure: the processor holds `cpu_valid`, `cpu_write`, `cpu_addr` and `cpu_wdata` stable until `cpu_ready`. The transfer completes in the cycle where both are high, and `cpu_rdata` is valid in that cycle for reads. There is no back-pressure on the bus or snoop side. Snoops arrive only while another master owns the bus.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid; `bus_req`, `cpu_ready`, `snp_shared` and `snp_flush` are low, and the first access to any address misses.
- R2: A read whose address tag matches a non-Invalid line completes with `cpu_ready` in the cycle it is presented, returns the line data, and issues no bus command.
- R3: A read miss raises `bus_req` and holds it until the cycle that completes the access. In the granted cycle the block drives `bus_cmd`=1 (read) with the request address and returns `bus_rdata` to the processor in that same cycle. `bus_req` is low in the cycle after.
- R4: A read fill enters Shared when `bus_shared` is high or `MESI_EN` is 0, and Exclusive otherwise.
- R5: A write to a Shared line issues `bus_cmd`=3 (upgrade) with no data fill. The line becomes Modified with the write data.
- R6: A write to an Exclusive or Modified line completes without a bus request and leaves the line Modified.
- R7: A write miss issues `bus_cmd`=2 (read-exclusive) and installs the write data in a Modified line.
- R8: Refilling an index that holds a different Modified line first issues `bus_cmd`=4 (writeback) with the victim address and data, then the fill, without releasing the bus. Replacing a clean line issues only the fill.
- R9: A snooped read (`snp_cmd`=1) that hits a Modified line asserts `snp_flush` with the line data on `snp_data`, plus `snp_shared`, in the same cycle. The line becomes Shared.
- R10: A snooped read that hits a Shared or Exclusive line asserts `snp_shared` without `snp_flush`. An Exclusive line becomes Shared.
- R11: A snooped read-exclusive (2) or upgrade (3) that hits a valid line makes it Invalid. If the line was Modified, read-exclusive also flushes its data.
- R12: A snooped writeback (4), a tag mismatch or an Invalid line gives no snoop response and leaves the line unchanged.
- R13: A snoop to the index of a pending processor request holds off `cpu_ready` in that cycle. A line invalidated while its write waits for grant is filled with read-exclusive instead of upgraded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready on reads |
| bus_req | output | 1 | Bus request, held through the whole transaction |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_rdata | input | DATA_W | Fill data, valid in the command cycle |
| bus_shared | input | 1 | Another cache holds the line being read |
| snp_valid | input | 1 | Snooped transaction valid |
| snp_cmd | input | 3 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_data | output | DATA_W | Supplied data |

## Verification
The hardest case to reach is a snoop that hits a line while the processor is already waiting for the bus. The command must then be re-chosen at grant time, and the same-index stall must hold off a local hit. The bench withholds the grant and runs the processor access and a snoop sequence in parallel branches. The snoop lands while the upgrade is still pending, or in the very cycle a hit is presented. Only after that is the grant released, and the bench checks the logged bus command and the supplied data.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LS_INV = 2'd0, LS_SHR = 2'd1, LS_EXC = 2'd2, LS_MOD = 2'd3} lstate_t;
  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_RD   = 3'd1,
    BC_RDX  = 3'd2,
    BC_UPG  = 3'd3,
    BC_WB   = 3'd4
  } bcmd_t;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 6,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output lstate_t           ra_state,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output lstate_t           rb_state,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wa_en,
  input  logic [IDX_W-1:0]  wa_idx,
  input  lstate_t           wa_state,
  input  logic [TAG_W-1:0]  wa_tag,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  lstate_t           wb_state
);
  lstate_t           st_arr  [NUM_LINES];
  logic [TAG_W-1:0]  tag_arr [NUM_LINES];
  logic [DATA_W-1:0] dat_arr [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    lstate_t           st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] dat_r;
    logic              sel_a, sel_b;
    assign sel_a = wa_en && (wa_idx == IDX_W'(i));
    assign sel_b = wb_en && (wb_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_r  <= LS_INV;
        tag_r <= '0;
        dat_r <= '0;
      end else if (sel_a) begin
        st_r  <= wa_state;
        tag_r <= wa_tag;
        dat_r <= wa_data;
      end else if (sel_b) begin
        st_r  <= wb_state;
      end
    end

    assign st_arr[i]  = st_r;
    assign tag_arr[i] = tag_r;
    assign dat_arr[i] = dat_r;
  end

  assign ra_state = st_arr[ra_idx];
  assign ra_tag   = tag_arr[ra_idx];
  assign ra_data  = dat_arr[ra_idx];
  assign rb_state = st_arr[rb_idx];
  assign rb_tag   = tag_arr[rb_idx];
  assign rb_data  = dat_arr[rb_idx];
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  lstate_t           line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              hit_shared,
  output logic              flush,
  output logic [DATA_W-1:0] flush_data,
  output logic              upd_en,
  output lstate_t           upd_state
);
  logic hit, dirty;
  assign hit   = snp_valid && (line_state != LS_INV) && (line_tag == snp_tag);
  assign dirty = (line_state == LS_MOD);

  always_comb begin
    hit_shared = 1'b0;
    flush      = 1'b0;
    upd_en     = 1'b0;
    upd_state  = LS_INV;
    case (snp_cmd)
      BC_RD: begin
        hit_shared = hit;
        flush      = hit && dirty;
        upd_en     = hit && (line_state != LS_SHR);
        upd_state  = LS_SHR;
      end
      BC_RDX: begin
        flush  = hit && dirty;
        upd_en = hit;
      end
      BC_UPG: begin
        upd_en = hit;
      end
      default: ;
    endcase
  end

  assign flush_data = flush ? line_data : '0;
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 2,
  parameter bit MESI_EN = 1'b1,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  lstate_t           line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  logic              snp_conflict,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  input  logic [DATA_W-1:0] bus_rdata,
  output bcmd_t             bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              wr_en,
  output lstate_t           wr_state,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);
  typedef enum logic {PH_IDLE, PH_BUS} phase_t;
  phase_t ph_q, ph_d;

  logic tag_eq, rd_hit, wr_hit, shr_wr;
  lstate_t fill_state;

  assign tag_eq = (line_tag == cpu_tag);
  assign rd_hit = !cpu_write && tag_eq && (line_state != LS_INV);
  assign wr_hit = cpu_write && tag_eq && (line_state == LS_EXC || line_state == LS_MOD);
  assign shr_wr = cpu_write && tag_eq && (line_state == LS_SHR);
  assign fill_state = cpu_write ? LS_MOD : ((bus_shared || !MESI_EN) ? LS_SHR : LS_EXC);

  always_comb begin
    ph_d      = ph_q;
    cpu_ready = 1'b0;
    cpu_rdata = '0;
    bus_cmd   = BC_NONE;
    bus_addr  = '0;
    bus_wdata = '0;
    wr_en     = 1'b0;
    wr_state  = line_state;
    wr_tag    = line_tag;
    wr_data   = line_data;
    case (ph_q)
      PH_IDLE: begin
        if (cpu_valid && !snp_conflict) begin
          if (rd_hit) begin
            cpu_ready = 1'b1;
            cpu_rdata = line_data;
          end else if (wr_hit) begin
            cpu_ready = 1'b1;
            wr_en     = 1'b1;
            wr_state  = LS_MOD;
            wr_data   = cpu_wdata;
          end else begin
            ph_d = PH_BUS;
          end
        end
      end
      default: begin
        if (bus_gnt) begin
          if (rd_hit) begin
            cpu_ready = 1'b1;
            cpu_rdata = line_data;
            ph_d      = PH_IDLE;
          end else if (wr_hit || shr_wr) begin
            bus_cmd   = shr_wr ? BC_UPG : BC_NONE;
            bus_addr  = {cpu_tag, cpu_idx};
            cpu_ready = 1'b1;
            wr_en     = 1'b1;
            wr_state  = LS_MOD;
            wr_data   = cpu_wdata;
            ph_d      = PH_IDLE;
          end else if (line_state == LS_MOD) begin
            bus_cmd   = BC_WB;
            bus_addr  = {line_tag, cpu_idx};
            bus_wdata = line_data;
            wr_en     = 1'b1;
            wr_state  = LS_INV;
          end else begin
            bus_cmd   = cpu_write ? BC_RDX : BC_RD;
            bus_addr  = {cpu_tag, cpu_idx};
            cpu_ready = 1'b1;
            cpu_rdata = bus_rdata;
            wr_en     = 1'b1;
            wr_state  = fill_state;
            wr_tag    = cpu_tag;
            wr_data   = cpu_write ? cpu_wdata : bus_rdata;
            ph_d      = PH_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign bus_req = (ph_q == PH_BUS);
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter bit MESI_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  lstate_t           a_state, b_state, wa_state, wb_state;
  logic [TAG_W-1:0]  a_tag, b_tag, wa_tag;
  logic [DATA_W-1:0] a_data, b_data, wa_data;
  logic              wa_en, wb_en, snp_conflict;
  bcmd_t             cmd_e;

  assign snp_conflict = snp_valid && (snp_idx == cpu_idx);

  coh_line_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(cpu_idx), .ra_state(a_state), .ra_tag(a_tag), .ra_data(a_data),
    .rb_idx(snp_idx), .rb_state(b_state), .rb_tag(b_tag), .rb_data(b_data),
    .wa_en(wa_en), .wa_idx(cpu_idx), .wa_state(wa_state), .wa_tag(wa_tag), .wa_data(wa_data),
    .wb_en(wb_en), .wb_idx(snp_idx), .wb_state(wb_state)
  );

  coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_tag),
    .line_state(b_state), .line_tag(b_tag), .line_data(b_data),
    .hit_shared(snp_shared), .flush(snp_flush), .flush_data(snp_data),
    .upd_en(wb_en), .upd_state(wb_state)
  );

  coh_req_fsm #(.TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .MESI_EN(MESI_EN)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_tag(cpu_tag), .cpu_idx(cpu_idx),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .line_state(a_state), .line_tag(a_tag), .line_data(a_data),
    .snp_conflict(snp_conflict),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_shared(bus_shared), .bus_rdata(bus_rdata),
    .bus_cmd(cmd_e), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wr_en(wa_en), .wr_state(wa_state), .wr_tag(wa_tag), .wr_data(wa_data)
  );

  assign bus_cmd = cmd_e;
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_valid,
  input logic             cpu_ready,
  input logic             cpu_write,
  input logic [IDX_W-1:0] cpu_idx,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic [2:0]       bus_cmd,
  input logic             snp_valid,
  input logic [2:0]       snp_cmd,
  input logic [IDX_W-1:0] snp_idx,
  input logic             snp_flush
);
  a_r2_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !cpu_ready) |=> bus_req);
  a_r3_req_released: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && cpu_ready) |=> !bus_req);
  a_r8_cmd_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 3'd0) |-> (bus_gnt && bus_req));
  a_r8_wb_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 3'd4) |=> bus_req);
  a_r5_upgrade_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 3'd3) |-> (cpu_write && cpu_ready));
  a_r9_flush_on_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && (snp_cmd == 3'd1 || snp_cmd == 3'd2)));
  a_r13_no_same_index_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && snp_valid) |-> (snp_idx != cpu_idx));
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
  .cpu_idx(cpu_addr[IDX_W-1:0]),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_addr[IDX_W-1:0]),
  .snp_flush(snp_flush)
);

// File: tb/coh_line_ctrl_tb.sv
`timescale 1ns/1ps
module coh_line_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_valid = 0, cpu_write = 0;
  logic [7:0]  cpu_addr = 0;
  logic [31:0] cpu_wdata = 0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_gnt = 0, bus_shared = 0;
  logic [2:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        snp_valid = 0;
  logic [2:0]  snp_cmd = 0;
  logic [7:0]  snp_addr = 0;
  logic        snp_shared, snp_flush;
  logic [31:0] snp_data;

  logic        gnt_en = 1;
  logic [31:0] mem [256];
  logic [2:0]  log_cmd  [64];
  logic [7:0]  log_addr [64];
  logic [31:0] log_data [64];
  int          nlog = 0;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  coh_line_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_shared(bus_shared),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_data(snp_data)
  );

  assign bus_rdata = mem[bus_addr];

  initial for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;

  always @(negedge clk) bus_gnt <= bus_req && gnt_en;

  always @(posedge clk) begin
    if (rst_n && bus_cmd != 3'd0 && nlog < 64) begin
      log_cmd[nlog]  = bus_cmd;
      log_addr[nlog] = bus_addr;
      log_data[nlog] = bus_wdata;
      nlog++;
      if (bus_cmd == 3'd4) mem[bus_addr] = bus_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] q);
    int n = 0;
    @(negedge clk);
    cpu_valid = 1; cpu_write = w; cpu_addr = a; cpu_wdata = d;
    #1;
    while (!cpu_ready && n < 50) begin @(negedge clk); #1; n++; end
    q = cpu_rdata;
    @(posedge clk);
    #1 cpu_valid = 0; cpu_write = 0;
  endtask

  task automatic snoop(input logic [2:0] c, input logic [7:0] a, input bit e_sh,
                       input bit e_fl, input logic [31:0] e_d, input string req);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1;
    chk(snp_shared == e_sh, req, "snp_shared", 32'(snp_shared), 32'(e_sh));
    chk(snp_flush == e_fl, req, "snp_flush", 32'(snp_flush), 32'(e_fl));
    if (e_fl) chk(snp_data == e_d, req, "snp_data", snp_data, e_d);
    @(posedge clk);
    #1 snp_valid = 0;
  endtask

  task automatic chk_log(input int idx, input logic [2:0] c, input logic [7:0] a, input string req);
    chk(nlog > idx, req, "log depth", 32'(nlog), 32'(idx + 1));
    if (nlog > idx) begin
      chk(log_cmd[idx] == c, req, "bus_cmd", 32'(log_cmd[idx]), 32'(c));
      chk(log_addr[idx] == a, req, "bus_addr", 32'(log_addr[idx]), 32'(a));
    end
  endtask

  // R1, R3, R4, R2
  task automatic t_read_miss_then_hit();
    logic [31:0] q;
    int n0 = nlog;
    bus_shared = 0;
    access(0, 8'h10, 0, q);
    chk(q == 32'hA000_0010, "R3", "fill data", q, 32'hA000_0010);
    chk_log(n0, 3'd1, 8'h10, "R3");
    chk(bus_req == 0, "R3", "req released", 32'(bus_req), 0);
    access(0, 8'h10, 0, q);
    chk(q == 32'hA000_0010, "R2", "hit data", q, 32'hA000_0010);
    chk(nlog == n0 + 1, "R2", "no bus on hit", 32'(nlog), 32'(n0 + 1));
  endtask

  // R6 (Exclusive silent write), R9, R5
  task automatic t_excl_write_and_flush();
    logic [31:0] q;
    int n0 = nlog;
    access(1, 8'h10, 32'h1111_1111, q);
    chk(nlog == n0, "R6", "silent write on E", 32'(nlog), 32'(n0));
    access(0, 8'h10, 0, q);
    chk(q == 32'h1111_1111, "R6", "written data", q, 32'h1111_1111);
    snoop(3'd1, 8'h10, 1, 1, 32'h1111_1111, "R9");
    access(1, 8'h10, 32'h2222_2222, q);
    chk_log(n0, 3'd3, 8'h10, "R5");
  endtask

  // R4 shared fill, R11
  task automatic t_shared_fill_invalidate();
    logic [31:0] q;
    int n0 = nlog;
    bus_shared = 1;
    access(0, 8'h21, 0, q);
    bus_shared = 0;
    chk_log(n0, 3'd1, 8'h21, "R4");
    access(1, 8'h21, 32'h3333_3333, q);
    chk_log(n0 + 1, 3'd3, 8'h21, "R4");
    snoop(3'd2, 8'h21, 0, 1, 32'h3333_3333, "R11");
    access(0, 8'h21, 0, q);
    chk_log(n0 + 2, 3'd1, 8'h21, "R11");
    chk(q == 32'hA000_0021, "R11", "refill data", q, 32'hA000_0021);
  endtask

  // R12
  task automatic t_ignored_snoops();
    logic [31:0] q;
    int n0 = nlog;
    snoop(3'd4, 8'h21, 0, 0, 0, "R12");
    snoop(3'd1, 8'h31, 0, 0, 0, "R12");
    access(1, 8'h21, 32'h4444_4444, q);
    chk(nlog == n0, "R12", "line still Exclusive", 32'(nlog), 32'(n0));
  endtask

  // R8
  task automatic t_evictions();
    logic [31:0] q;
    int n0 = nlog;
    access(0, 8'h30, 0, q);
    chk_log(n0, 3'd4, 8'h10, "R8");
    if (nlog > n0) chk(log_data[n0] == 32'h2222_2222, "R8", "wb data", log_data[n0], 32'h2222_2222);
    chk_log(n0 + 1, 3'd1, 8'h30, "R8");
    chk(q == 32'hA000_0030, "R8", "fill after wb", q, 32'hA000_0030);
    access(0, 8'h02, 0, q);
    access(0, 8'h06, 0, q);
    chk(nlog == n0 + 4, "R8", "clean eviction silent", 32'(nlog), 32'(n0 + 4));
    chk_log(n0 + 3, 3'd1, 8'h06, "R8");
  endtask

  // R10, R7
  task automatic t_excl_snoop_and_write_miss();
    logic [31:0] q;
    int n0 = nlog;
    snoop(3'd1, 8'h06, 1, 0, 0, "R10");
    access(1, 8'h06, 32'h5555_5555, q);
    chk_log(n0, 3'd3, 8'h06, "R10");
    access(1, 8'h07, 32'h6666_6666, q);
    chk_log(n0 + 1, 3'd2, 8'h07, "R7");
    snoop(3'd1, 8'h07, 1, 1, 32'h6666_6666, "R7");
  endtask

  // R13
  task automatic t_races();
    logic [31:0] q;
    int n0 = nlog;
    gnt_en = 0;
    fork
      access(1, 8'h07, 32'h7777_7777, q);
      begin
        repeat (3) @(negedge clk);
        snoop(3'd2, 8'h07, 0, 0, 0, "R13");
        gnt_en = 1;
      end
    join
    chk_log(n0, 3'd2, 8'h07, "R13");
    chk(nlog == n0 + 1, "R13", "single command", 32'(nlog), 32'(n0 + 1));
    fork
      access(0, 8'h07, 0, q);
      begin
        @(negedge clk);
        snp_valid = 1; snp_cmd = 3'd1; snp_addr = 8'h07;
        #1;
        chk(cpu_ready == 0, "R13", "stall on same index", 32'(cpu_ready), 0);
        chk(snp_flush == 1 && snp_data == 32'h7777_7777, "R13", "flush data", snp_data, 32'h7777_7777);
        @(posedge clk);
        #1 snp_valid = 0;
      end
    join
    chk(q == 32'h7777_7777, "R13", "hit after stall", q, 32'h7777_7777);
    chk(nlog == n0 + 1, "R13", "no bus after stall", 32'(nlog), 32'(n0 + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(bus_req == 0 && cpu_ready == 0, "R1", "idle outputs", {bus_req, cpu_ready}, 0);
    chk(snp_shared == 0 && snp_flush == 0, "R1", "snoop outputs", {snp_shared, snp_flush}, 0);
    t_read_miss_then_hit();
    t_excl_write_and_flush();
    t_shared_fill_invalidate();
    t_ignored_snoops();
    t_evictions();
    t_excl_snoop_and_write_miss();
    t_races();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule